// File: doc/BRIEF.md
# One-plus-lambda evolution controller

This block sequences a (1+λ) evolutionary search over the genotype of a small feed-forward gate array. After `start` it draws a random first parent that already obeys the wiring rules, has it scored, then runs generations. In each generation it copies the parent into a single child buffer λ times, changes a few genes of each copy and asks an outside evaluator for a score through a start/done handshake. The best child becomes the next parent. A run ends when the parent reaches the maximum score or when the generation limit is used up.

Only one child buffer exists. When a generation ends with a winner, that winner is rebuilt from the saved state of the pseudo-random generator at the moment its mutation began. The winning genotype is therefore never stored next to the child. A 32-bit LFSR chooses which genes change and their new values. Every drawn value is folded into the legal range for the gene's position. The evaluator decodes the genotype from `eval_geno`, and the current parent stays readable on `best_geno`.

Top module: `evo_search_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it: `busy`, `done` and `eval_start` are 0, and `gen_count` and `best_fit` are 0. A reset in the middle of a run returns the block to this state.
- R2: `start`, when sampled in idle, begins a run: `busy` rises, `done` clears, `gen_count` returns to 0 and `gen_limit` is latched. `start` has no effect while `busy` is high.
- R3: Gene g sits at bits [5g+4:5g] of a genotype. Cell c (0..3) owns genes 4c..4c+3: three input connections, then one function gene. Output o is gene 16+o. A connection of cell c holds either a primary input 0..2, or a node 3+j with max(0,c-2) <= j < c. The outputs use the same rule with c = 4. The first genotype evaluated in a run is random and obeys this rule.
- R4: Every function gene that is presented or stored is one of the codes 6, 10 or 16.
- R5: Each generation presents exactly 4 children. Each one is the generation's parent with at most 2 genes changed. The count of changes is forced to at least one even if it is configured as zero.
- R6: A child whose score is greater than or equal to the best score so far in the generation becomes the next parent; that running best starts at the parent's score. Among equal scores the later child wins. If no child qualifies, the parent and `best_fit` stay as they were.
- R7: `eval_start` is a one-cycle pulse while `eval_geno` holds the genotype to score. The controller waits as long as needed for `eval_done` and samples `eval_fitness` in that cycle.
- R8: The stop test runs after the first parent has been scored and after every generation. The run stops if `best_fit` equals 16, or if `gen_count` has reached the latched limit. A limit of 0 gives a run with only the first evaluation.
- R9: Once a run has stopped, `done` stays high and `busy` stays low, and `best_geno`, `best_fit` and `gen_count` hold until the next start. `busy` and `done` are never high together.
- R10: During a run, `gen_count` goes up by one per completed generation and `best_fit` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (ignored when busy) |
| gen_limit | input | 8 | Maximum generations, latched at start |
| eval_start | output | 1 | One-cycle request to score `eval_geno` |
| eval_geno | output | 90 | Genotype to be scored |
| eval_done | input | 1 | Score is valid this cycle |
| eval_fitness | input | 5 | Score for the outstanding request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run has stopped |
| gen_count | output | 8 | Completed generations |
| best_fit | output | 5 | Score of the current parent |
| best_geno | output | 90 | Current parent genotype |

## Verification
The scripted scores include several cases. Two children in one generation tie, and the later one must win. A child only equals the parent's score, and it must still take over. In one generation no child qualifies, so the rebuild step must be skipped. A design that keeps the earlier tie, or that rebuilds the wrong child from the saved generator state, hands on a parent that differs from the genotype the bench recorded. That shows up in the next generation's distance checks and in `best_geno`. A limit of zero, a first parent that already has the full score, and a full score reached partway through a generation all test the stop rule; an off-by-one there changes the evaluation count and `gen_count`. A start pulse during a run and a reset during a run catch a controller that restarts at the wrong moment or keeps stale state.

// File: rtl/evo_pkg.sv
`timescale 1ns/1ps
// Shared types for the evolution controller.
// Assumes: one controller state machine per instance.
package evo_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_INIT, ST_REQ, ST_WAIT, ST_COPY, ST_MUT,
        ST_RCOPY, ST_RMUT, ST_RAPPLY, ST_GEND, ST_CHECK
    } evo_state_e;
endpackage

// File: rtl/evo_lfsr.sv
`timescale 1ns/1ps
// Galois LFSR used for every random draw of the controller.
// Assumes: SEED is non-zero; load takes priority over step.
module evo_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h1ACE_B00C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] state
);
    // Advance, reload or reset the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)     state <= SEED;
        else if (load)  state <= load_val;
        else if (step)  state <= (state >> 1) ^ (state[0] ? TAPS : '0);
    end
endmodule

// File: rtl/evo_gene_draw.sv
`timescale 1ns/1ps
// Maps a random byte onto a legal value for one gene position.
// Connection genes: primary input or a node inside the levels-back window.
// Function genes: one entry of the allowed function set.
// Assumes: gene_idx < number of genes; rows fixed at one.
module evo_gene_draw #(
    parameter int N_IN    = 3,
    parameter int N_COL   = 4,
    parameter int N_ARITY = 3,
    parameter int LBACK   = 2,
    parameter int N_FUNC  = 3,
    parameter int FW      = 5,
    parameter logic [N_FUNC*FW-1:0] FUNC_SET = {5'd16, 5'd10, 5'd6},
    parameter int GW      = 5,
    parameter int IW      = 5
) (
    input  logic [IW-1:0] gene_idx,
    input  logic [7:0]    rnd,
    output logic [GW-1:0] gene_val
);
    localparam int CPG        = N_ARITY + 1;
    localparam int CELL_GENES = N_COL * CPG;

    // Decode the position and fold the draw into its legal range.
    always_comb begin
        int col;
        int win;
        int span;
        int r;
        int idx;
        logic is_fn;
        idx = int'({{(32-IW){1'b0}}, gene_idx});
        if (idx < CELL_GENES) begin
            col   = idx / CPG;
            is_fn = (idx % CPG) == N_ARITY;
        end else begin
            col   = N_COL;
            is_fn = 1'b0;
        end
        win      = (col < LBACK) ? col : LBACK;
        span     = N_IN + win;
        r        = int'({24'd0, rnd}) % span;
        gene_val = '0;
        if (is_fn) begin
            for (int f = 0; f < N_FUNC; f++)
                if ((int'({24'd0, rnd}) % N_FUNC) == f)
                    gene_val = GW'(FUNC_SET[f*FW +: FW]);
        end else if (r < N_IN) begin
            gene_val = GW'(r);
        end else begin
            gene_val = GW'(col - win + r);
        end
    end
endmodule

// File: rtl/evo_search_ctrl.sv
`timescale 1ns/1ps
// (1+lambda) evolution controller with one child buffer.
// Draws a legal random parent, then per generation builds LAMBDA mutated
// children in turn, scores each through the start/done handshake and
// rebuilds the winner from its saved generator state.
// Assumes: evaluator answers each eval_start with exactly one eval_done.
module evo_search_ctrl
    import evo_pkg::*;
#(
    parameter int N_IN    = 3,
    parameter int N_OUT   = 2,
    parameter int N_COL   = 4,
    parameter int N_ARITY = 3,
    parameter int LBACK   = 2,
    parameter int FW      = 5,
    parameter int N_FUNC  = 3,
    parameter logic [N_FUNC*FW-1:0] FUNC_SET = {5'd16, 5'd10, 5'd6},
    parameter int LAMBDA  = 4,
    parameter int N_MUT   = 2,
    parameter int FIT_W   = 5,
    parameter int MAX_FIT = 16,
    parameter int GEN_W   = 8,
    parameter logic [31:0] SEED = 32'h1ACE_B00C,
    localparam int CW      = $clog2(N_IN + N_COL),
    localparam int GW      = (CW > FW) ? CW : FW,
    localparam int N_GENES = N_COL * (N_ARITY + 1) + N_OUT,
    localparam int GENO_W  = N_GENES * GW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [GEN_W-1:0]  gen_limit,
    output logic              eval_start,
    output logic [GENO_W-1:0] eval_geno,
    input  logic              eval_done,
    input  logic [FIT_W-1:0]  eval_fitness,
    output logic              busy,
    output logic              done,
    output logic [GEN_W-1:0]  gen_count,
    output logic [FIT_W-1:0]  best_fit,
    output logic [GENO_W-1:0] best_geno
);
    localparam int IW    = $clog2(N_GENES + 1);
    localparam int KW    = $clog2(LAMBDA + 1);
    localparam int MUT_N = (N_MUT < 1) ? 1 : N_MUT;

    evo_state_e       state;
    logic [GW-1:0]    par_g [N_GENES];
    logic [GW-1:0]    kid_g [N_GENES];
    logic [IW-1:0]    cnt;
    logic [KW-1:0]    kid;
    logic [FIT_W-1:0] pfit, gbest;
    logic             won, boot;
    logic [31:0]      rng, snap, win_seed, resume, rng_load_val;
    logic [GEN_W-1:0] gens, lim;
    logic             rng_step, rng_load, mutating;
    logic [IW-1:0]    pick_idx, draw_idx;
    logic [GW-1:0]    draw_val;

    // Select the gene to draw and drive the generator controls.
    always_comb begin
        mutating     = (state == ST_INIT) || (state == ST_MUT) || (state == ST_RMUT);
        pick_idx     = IW'({24'd0, rng[15:8]} % 32'(N_GENES));
        draw_idx     = (state == ST_INIT) ? cnt : pick_idx;
        rng_step     = mutating;
        rng_load     = (state == ST_RCOPY) || (state == ST_RAPPLY);
        rng_load_val = (state == ST_RCOPY) ? win_seed : resume;
    end

    evo_lfsr #(.W(32), .SEED(SEED)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .step(rng_step), .load(rng_load),
        .load_val(rng_load_val), .state(rng)
    );

    evo_gene_draw #(
        .N_IN(N_IN), .N_COL(N_COL), .N_ARITY(N_ARITY), .LBACK(LBACK),
        .N_FUNC(N_FUNC), .FW(FW), .FUNC_SET(FUNC_SET), .GW(GW), .IW(IW)
    ) i_draw (
        .gene_idx(draw_idx), .rnd(rng[7:0]), .gene_val(draw_val)
    );

    // Run sequencing: init, evaluation, selection, replay and stop test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; cnt <= '0; kid <= '0; pfit <= '0; gbest <= '0;
            won <= 1'b0; boot <= 1'b0; snap <= '0; win_seed <= '0; resume <= '0;
            gens <= '0; lim <= '0; busy <= 1'b0; done <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    busy <= 1'b1; done <= 1'b0; gens <= '0; lim <= gen_limit;
                    pfit <= '0; cnt <= '0; boot <= 1'b1; state <= ST_INIT;
                end
                ST_INIT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == IW'(N_GENES - 1)) state <= ST_REQ;
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: if (eval_done) begin
                    if (boot) begin
                        boot <= 1'b0; pfit <= eval_fitness; state <= ST_CHECK;
                    end else begin
                        if (eval_fitness >= gbest) begin
                            gbest <= eval_fitness; won <= 1'b1; win_seed <= snap;
                        end
                        if (kid == KW'(LAMBDA - 1))
                            state <= (won || eval_fitness >= gbest) ? ST_RCOPY : ST_GEND;
                        else begin
                            kid <= kid + 1'b1; state <= ST_COPY;
                        end
                    end
                end
                ST_COPY: begin snap <= rng; cnt <= '0; state <= ST_MUT; end
                ST_MUT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == IW'(MUT_N - 1)) state <= ST_REQ;
                end
                ST_RCOPY: begin resume <= rng; cnt <= '0; state <= ST_RMUT; end
                ST_RMUT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == IW'(MUT_N - 1)) state <= ST_RAPPLY;
                end
                ST_RAPPLY: begin pfit <= gbest; state <= ST_GEND; end
                ST_GEND:   begin gens <= gens + 1'b1; state <= ST_CHECK; end
                ST_CHECK: begin
                    if (pfit >= FIT_W'(MAX_FIT) || gens >= lim) begin
                        busy <= 1'b0; done <= 1'b1; state <= ST_IDLE;
                    end else begin
                        gbest <= pfit; won <= 1'b0; kid <= '0; state <= ST_COPY;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Genotype storage: child copy/mutate, parent promotion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_GENES; i++) begin
                par_g[i] <= '0;
                kid_g[i] <= '0;
            end
        end else begin
            if (state == ST_COPY || state == ST_RCOPY) begin
                for (int i = 0; i < N_GENES; i++) kid_g[i] <= par_g[i];
            end else if (mutating) begin
                kid_g[draw_idx] <= draw_val;
            end
            if ((state == ST_WAIT && eval_done && boot) || state == ST_RAPPLY) begin
                for (int i = 0; i < N_GENES; i++) par_g[i] <= kid_g[i];
            end
        end
    end

    // Flatten the genotype stores onto the ports.
    for (genvar g = 0; g < N_GENES; g++) begin : g_flat
        assign eval_geno[g*GW +: GW] = kid_g[g];
        assign best_geno[g*GW +: GW] = par_g[g];
    end

    assign eval_start = (state == ST_REQ);
    assign gen_count  = gens;
    assign best_fit   = pfit;
endmodule

// File: rtl/evo_search_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol and progress properties of the evolution controller.
// Assumes: attached by the bind below; reset is synchronous active-low.
module evo_search_ctrl_chk #(
    parameter int FIT_W  = 5,
    parameter int GEN_W  = 8,
    parameter int GENO_W = 90
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              eval_start,
    input logic [GEN_W-1:0]  gen_count,
    input logic [FIT_W-1:0]  best_fit,
    input logic [GENO_W-1:0] best_geno
);
    // R7: a request lasts exactly one cycle.
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eval_start |=> !eval_start);

    // R9: running and finished are exclusive.
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9: results are frozen between runs.
    a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !busy && !$past(busy) && !$past(start))
        |-> ($stable(best_geno) && $stable(best_fit) && $stable(gen_count)));

    // R10: parent score never falls during a run.
    a_r10_fit_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && busy && $past(busy)) |-> (best_fit >= $past(best_fit)));

    // R10: generation counter moves by at most one.
    a_r10_gen_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && busy && $past(busy))
        |-> (gen_count == $past(gen_count) || gen_count == $past(gen_count) + 1'b1));
endmodule

bind evo_search_ctrl evo_search_ctrl_chk #(
    .FIT_W(FIT_W), .GEN_W(GEN_W), .GENO_W(GENO_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .eval_start(eval_start), .gen_count(gen_count), .best_fit(best_fit),
    .best_geno(best_geno)
);

// File: tb/test_evo_search_ctrl.sv
`timescale 1ns/1ps
module test_evo_search_ctrl;
    localparam int GENO_W = 90;
    localparam int NG     = 18;
    localparam int NV     = 6;
    localparam int NS     = 13;

    // Per vector: generation limit, scripted scores, expected generations and score.
    localparam int V_LIMIT [NV] = '{3, 5, 0, 4, 2, 2};
    localparam int V_GEN   [NV] = '{3, 1, 0, 0, 2, 2};
    localparam int V_BEST  [NV] = '{9, 16, 7, 16, 10, 1};
    localparam int V_POKE  [NV] = '{0, 0, 0, 0, 0, 1};
    localparam int V_SC [NV][NS] = '{
        '{5, 4, 6, 6, 2, 6, 3, 1, 0, 7, 9, 8, 9},
        '{3, 1, 16, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0},
        '{7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
        '{16, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
        '{10, 2, 3, 4, 5, 10, 1, 1, 1, 0, 0, 0, 0},
        '{1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [7:0]        gen_limit;
    logic              eval_start;
    logic [GENO_W-1:0] eval_geno;
    logic              eval_done;
    logic [4:0]        eval_fitness;
    logic              busy, done;
    logic [7:0]        gen_count;
    logic [4:0]        best_fit;
    logic [GENO_W-1:0] best_geno;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    evo_search_ctrl i_evo_search_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .gen_limit(gen_limit),
        .eval_start(eval_start), .eval_geno(eval_geno), .eval_done(eval_done),
        .eval_fitness(eval_fitness), .busy(busy), .done(done),
        .gen_count(gen_count), .best_fit(best_fit), .best_geno(best_geno)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [GENO_W-1:0] act, input logic [GENO_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Legality of one gene value at one position (cells, then outputs).
    function automatic bit gene_ok(input int idx, input int v);
        int col, lo;
        if (idx < 16 && (idx % 4) == 3) return (v == 6 || v == 10 || v == 16);
        col = (idx < 16) ? idx / 4 : 4;
        lo  = (col > 2) ? col - 2 : 0;
        return (v < 3) || (v >= 3 + lo && v < 3 + col);
    endfunction

    function automatic bit geno_ok(input logic [GENO_W-1:0] g);
        for (int i = 0; i < NG; i++)
            if (!gene_ok(i, int'(g[i*5 +: 5]))) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int geno_dist(input logic [GENO_W-1:0] a, input logic [GENO_W-1:0] b);
        int d = 0;
        for (int i = 0; i < NG; i++)
            if (a[i*5 +: 5] != b[i*5 +: 5]) d++;
        return d;
    endfunction

    task automatic run_case(input int v);
        int n = 0;
        int k, sc, gb, mfit, dly;
        bit won = 1'b0;
        logic [GENO_W-1:0] g, mpar, cand;
        mpar = '0; cand = '0; mfit = 0; gb = 0;
        gen_limit = 8'(V_LIMIT[v]);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R2", "run begins", GENO_W'(busy), 1);
        for (int cyc = 0; cyc < 4000 && !done; cyc++) begin
            if (eval_start) begin
                g = eval_geno;
                chk(geno_ok(g), "R3 R4", "genotype legality", g, '0);
                sc = (n < NS) ? V_SC[v][n] : 0;
                if (n >= NS) chk(1'b0, "R8", "extra evaluation", GENO_W'(n), NS);
                if (n == 0) begin
                    mpar = g; mfit = sc;
                end else begin
                    k = (n - 1) % 4;
                    if (k == 0) begin
                        gb = mfit; won = 1'b0;
                        chk(best_geno == mpar, "R6", "parent entering generation", best_geno, mpar);
                    end
                    chk(geno_dist(g, mpar) <= 2, "R5", "child distance to parent",
                        GENO_W'(geno_dist(g, mpar)), 2);
                    if (sc >= gb) begin gb = sc; cand = g; won = 1'b1; end
                    if (k == 3 && won) begin mpar = cand; mfit = gb; end
                end
                if (V_POKE[v] != 0 && n == 3) start = 1'b1;
                dly = (n % 3) + 1;
                repeat (dly) @(negedge clk);
                start = 1'b0;
                eval_done = 1'b1; eval_fitness = 5'(sc);
                @(negedge clk);
                eval_done = 1'b0;
                n++;
            end else begin
                @(negedge clk);
            end
        end
        chk(done == 1'b1 && busy == 1'b0, "R9", "stopped flags", GENO_W'({busy, done}), 1);
        chk(gen_count == 8'(V_GEN[v]), "R8", "final generation count", GENO_W'(gen_count), GENO_W'(V_GEN[v]));
        chk(best_fit == 5'(V_BEST[v]) && int'(best_fit) == mfit, "R6", "final best score",
            GENO_W'(best_fit), GENO_W'(V_BEST[v]));
        chk(best_geno == mpar, "R6", "final parent genotype", best_geno, mpar);
        chk(n == 1 + 4 * V_GEN[v], "R5", "evaluations in run", GENO_W'(n), GENO_W'(1 + 4 * V_GEN[v]));
    endtask

    // Watchdog: a hung handshake is a failure (R7).
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual hang expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [GENO_W-1:0] hold_g;
        logic [7:0]        hold_n;
        logic [4:0]        hold_f;
        rst_n = 1'b0; start = 1'b0; gen_limit = '0; eval_done = 1'b0; eval_fitness = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !eval_start, "R1", "control flags after reset",
            GENO_W'({busy, done, eval_start}), 0);
        chk(gen_count == 0 && best_fit == 0, "R1", "counters after reset",
            GENO_W'({gen_count, best_fit}), 0);

        for (int v = 0; v < NV; v++) run_case(v);

        // R9: results hold while idle
        hold_g = best_geno; hold_n = gen_count; hold_f = best_fit;
        repeat (10) @(negedge clk);
        chk(done && !busy, "R9", "done held", GENO_W'({busy, done}), 1);
        chk(best_geno == hold_g && gen_count == hold_n && best_fit == hold_f, "R9",
            "results held", best_geno, hold_g);

        // R1: reset in the middle of a run
        gen_limit = 8'd5;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 100 && !eval_start; c++) @(negedge clk);
        chk(eval_start == 1'b1, "R7", "request issued", GENO_W'(eval_start), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !eval_start && gen_count == 0 && best_fit == 0, "R1",
            "state after reset mid-run", GENO_W'({busy, done, eval_start, gen_count, best_fit}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule